// File: doc/BRIEF.md
# Fault-Hardened Cipher Round Counter

This block sequences the rounds of an iterative block cipher and protects that sequence against fault injection. A start pulse latches the number of rounds from a key-length code. Each accepted advance strobe then moves the executed-round count up by one and a redundant remaining-round count down by one. The executed count is held together with a stored parity bit. Every cycle, a checker confirms that the two counts add up to the latched total and that the stored parity matches the count.

A failed check, or a start pulse with an unusable key-length code, raises an alert. The alert stays set until reset, and while it is set the counters no longer move. The surrounding cipher controller reads the round index and the last-round and done flags to steer its datapath. It treats the alert as terminal.

Top module: `fault_round_ctr`

## Requirements
- R1: During and after reset, before any start, the outputs are round_o = 0, last_o = 0, done_o = 1 and alert_o = 0.
- R2: A start pulse with key_len_i = 2'b00, 2'b01 or 2'b10 sets the remaining count to 10, 12 or 14 respectively, and sets round_o to 0. Both values are visible one cycle after the start.
- R3: Each advance strobe that is accepted raises round_o by one in the following cycle and lowers the remaining count by one.
- R4: last_o is 1 exactly when the remaining count is 1, and done_o is 1 exactly when it is 0.
- R5: An advance strobe is ignored while done_o is 1. When start and advance are high in the same cycle, the start wins and the advance is ignored.
- R6: A start pulse with key_len_i = 2'b11 raises alert_o in the next cycle and loads a total of 0, so round_o = 0 and done_o = 1.
- R7: Once alert_o is 1 it stays 1 until reset. While it is 1, start and advance have no effect on round_o, last_o or done_o.
- R8: Along any legal sequence of start and advance, the stored parity equals the XOR of the executed count, the two counts sum to the latched total, and alert_o stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Load pulse: clears the executed count and latches the round total |
| key_len_i | input | 2 | Key-length code sampled with start_i |
| advance_i | input | 1 | Advance strobe, one round per accepted cycle |
| round_o | output | 4 | Executed-round index |
| last_o | output | 1 | Exactly one round remains |
| done_o | output | 1 | No rounds remain |
| alert_o | output | 1 | Sticky fault alert |

## Verification
The hardest condition to reach from the ports is the alert state. The redundancy checks cannot fail in a fault-free design, so the only port-level route to the alert is a start pulse carrying the illegal key-length code 2'b11. The stimulus uses that code in directed cases, and occasionally in the random phase, to enter the alert state. It then shows that later starts and advances leave every output frozen until reset. Long random runs with legal codes show that the consistency checks never raise a false alert across restarts, advances issued after done, and starts that collide with an advance.

// File: rtl/rc_pkg.sv
// Package: shared widths, key-length codes and helper functions for the
// fault-hardened round counter. Assumes round totals fit in CNT_W bits.
package rc_pkg;
    localparam int CNT_W  = 4;
    localparam int KLEN_W = 2;

    typedef enum logic [KLEN_W-1:0] {
        KLEN_SHORT = 2'b00,
        KLEN_MID   = 2'b01,
        KLEN_LONG  = 2'b10,
        KLEN_BAD   = 2'b11
    } klen_e;

    // Round total per key-length code; 0 for the illegal code.
    function automatic logic [CNT_W-1:0] rounds_for(input logic [KLEN_W-1:0] code);
        case (code)
            KLEN_SHORT: rounds_for = CNT_W'(10);
            KLEN_MID:   rounds_for = CNT_W'(12);
            KLEN_LONG:  rounds_for = CNT_W'(14);
            default:    rounds_for = '0;
        endcase
    endfunction

    // Even parity over a count value.
    function automatic logic even_par(input logic [CNT_W-1:0] v);
        even_par = ^v;
    endfunction
endpackage

// File: rtl/rc_total_sel.sv
// Module: decodes the key-length code into a round total and flags the
// illegal code. Purely combinational; the caller latches the result.
module rc_total_sel
    import rc_pkg::*;
#(
    parameter int W  = CNT_W,
    parameter int KW = KLEN_W
) (
    input  logic [KW-1:0] code_i,
    output logic [W-1:0]  total_o,
    output logic          bad_o
);
    // Map code to total and detect the illegal code.
    always_comb begin
        total_o = W'(rounds_for(code_i));
        bad_o   = (code_i == KLEN_BAD);
    end
endmodule

// File: rtl/rc_exec_ctr.sv
// Module: executed-round up-counter with a stored parity bit.
// Assumes clr_i has priority over step_i; the caller never steps past max.
module rc_exec_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         step_i,
    output logic [W-1:0] cnt_o,
    output logic         par_o
);
    logic [W-1:0] cnt_d;

    // Next count: clear, step, or hold.
    always_comb begin
        cnt_d = cnt_o;
        if (clr_i)       cnt_d = '0;
        else if (step_i) cnt_d = cnt_o + W'(1);
    end

    // Count and parity registers, updated together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
            par_o <= 1'b0;
        end else begin
            cnt_o <= cnt_d;
            par_o <= ^cnt_d;
        end
    end

    p_step_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clr_i) |=> (cnt_o == $past(cnt_o) + W'(1)));
    p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_o == '0));
endmodule

// File: rtl/rc_rem_ctr.sv
// Module: remaining-round down-counter. Loads a total, steps down.
// Assumes load_i has priority and the caller never steps below zero.
module rc_rem_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         step_i,
    output logic [W-1:0] rem_o
);
    // Remaining-count register.
    always_ff @(posedge clk) begin
        if (!rst_n)      rem_o <= '0;
        else if (load_i) rem_o <= load_val_i;
        else if (step_i) rem_o <= rem_o - W'(1);
    end

    p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |=> (rem_o == $past(rem_o) - W'(1)));
    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rem_o == '0 && !load_i) |=> (rem_o == '0));
endmodule

// File: rtl/rc_fault_chk.sv
// Module: redundancy checker. Flags a mismatch when the two counts do
// not sum to the latched total or the stored parity disagrees with the count.
module rc_fault_chk #(
    parameter int W = 4
) (
    input  logic [W-1:0] cnt_i,
    input  logic         par_i,
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] total_i,
    output logic         fault_o
);
    localparam int SW = W + 1;
    logic [SW-1:0] sum;
    logic          sum_bad;
    logic          par_bad;

    // Widened sum comparison and parity recompute.
    always_comb begin
        sum     = SW'(cnt_i) + SW'(rem_i);
        sum_bad = (sum != SW'(total_i));
        par_bad = ((^cnt_i) != par_i);
        fault_o = sum_bad | par_bad;
    end
endmodule

// File: rtl/fault_round_ctr.sv
// Module: top of the fault-hardened round counter. Latches the round
// total at start, steps two redundant counters on advance, and raises a
// sticky alert on an illegal code or a failed consistency check.
// Assumes start_i and advance_i are synchronous to clk.
module fault_round_ctr
    import rc_pkg::*;
#(
    parameter int W  = CNT_W,
    parameter int KW = KLEN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [KW-1:0] key_len_i,
    input  logic          advance_i,
    output logic [W-1:0]  round_o,
    output logic          last_o,
    output logic          done_o,
    output logic          alert_o
);
    logic [W-1:0] total_sel, total_q, cnt, rem;
    logic         bad_code, par, fault, load, step;

    rc_total_sel #(.W(W), .KW(KW)) u_sel (
        .code_i (key_len_i),
        .total_o(total_sel),
        .bad_o  (bad_code)
    );

    // Accept start or advance only while no alert; start wins.
    always_comb begin
        load = start_i && !alert_o;
        step = advance_i && !start_i && !alert_o && (rem != '0);
    end

    // Latched round total.
    always_ff @(posedge clk) begin
        if (!rst_n)    total_q <= '0;
        else if (load) total_q <= total_sel;
    end

    rc_exec_ctr #(.W(W)) u_exec (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (load),
        .step_i(step),
        .cnt_o (cnt),
        .par_o (par)
    );

    rc_rem_ctr #(.W(W)) u_rem (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .load_val_i(total_sel),
        .step_i    (step),
        .rem_o     (rem)
    );

    rc_fault_chk #(.W(W)) u_chk (
        .cnt_i  (cnt),
        .par_i  (par),
        .rem_i  (rem),
        .total_i(total_q),
        .fault_o(fault)
    );

    // Sticky alert register.
    always_ff @(posedge clk) begin
        if (!rst_n) alert_o <= 1'b0;
        else        alert_o <= alert_o | fault | (load & bad_code);
    end

    // Output flags from the remaining count.
    always_comb begin
        round_o = cnt;
        last_o  = (rem == W'(1));
        done_o  = (rem == '0);
    end

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        alert_o |=> alert_o);
    p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        alert_o |=> ($stable(cnt) && $stable(rem)));
    p_done_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> $stable(round_o));
    p_bad_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && key_len_i == KLEN_BAD) |=> alert_o);
    p_consistent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!alert_o) |-> (({1'b0, cnt} + {1'b0, rem}) == {1'b0, total_q}));
    p_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(last_o && done_o));
endmodule

// File: tb/tb_fault_round_ctr.sv
`timescale 1ns/1ps
module tb_fault_round_ctr;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [1:0] key_len_i = 2'b00;
    logic       advance_i = 1'b0;
    logic [3:0] round_o;
    logic       last_o, done_o, alert_o;

    int checks = 0;
    int fails  = 0;
    logic [3:0] m_up = '0;
    logic [3:0] m_rem = '0;
    logic       m_err = 1'b0;

    always #5 clk = ~clk;

    fault_round_ctr dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .key_len_i(key_len_i),
        .advance_i(advance_i), .round_o(round_o), .last_o(last_o),
        .done_o(done_o), .alert_o(alert_o)
    );

    function automatic logic [3:0] exp_total(input logic [1:0] k);
        case (k)
            2'b00: return 4'd10;
            2'b01: return 4'd12;
            2'b10: return 4'd14;
            default: return 4'd0;
        endcase
    endfunction

    task automatic chk(input string req);
        logic [6:0] act, exp;
        act = {round_o, last_o, done_o, alert_o};
        exp = {m_up, (m_rem == 4'd1), (m_rem == 4'd0), m_err};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: {round,last,done,alert} actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Apply one cycle of stimulus at negedge, update model, check at next negedge.
    task automatic cyc(input logic s, input logic [1:0] k, input logic a, input string req);
        start_i = s; key_len_i = k; advance_i = a;
        @(posedge clk);
        if (!m_err) begin
            if (s) begin
                m_up = '0; m_rem = exp_total(k);
                if (k == 2'b11) m_err = 1'b1;
            end else if (a && m_rem != 0) begin
                m_up = m_up + 4'd1; m_rem = m_rem - 4'd1;
            end
        end
        @(negedge clk);
        chk(req);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; start_i = 0; advance_i = 0;
        @(posedge clk); @(negedge clk);
        m_up = '0; m_rem = '0; m_err = 1'b0;
        chk("R1 in reset");
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R1 after reset");
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        do_reset();
        // R2/R3/R4: each legal code, run to done
        for (int k = 0; k < 3; k++) begin
            cyc(1'b1, 2'(k), 1'b0, "R2 load total");
            for (int i = 0; i < 15; i++) cyc(1'b0, 2'(k), 1'b1, "R3 R4 stepping");
            cyc(1'b0, 2'(k), 1'b1, "R5 advance after done");
        end
        // R5: start beats advance in same cycle
        cyc(1'b1, 2'b00, 1'b0, "R2 restart");
        cyc(1'b0, 2'b00, 1'b1, "R3 one step");
        cyc(1'b1, 2'b01, 1'b1, "R5 start wins");
        // R6/R7: illegal code, then frozen
        cyc(1'b1, 2'b11, 1'b0, "R6 bad code");
        cyc(1'b1, 2'b10, 1'b0, "R7 start ignored");
        cyc(1'b0, 2'b10, 1'b1, "R7 advance ignored");
        do_reset();
        cyc(1'b1, 2'b10, 1'b0, "R2 after reset");
        for (int i = 0; i < 13; i++) cyc(1'b0, 2'b10, 1'b1, "R4 last near end");
        cyc(1'b1, 2'b11, 1'b1, "R6 bad code with advance");
        cyc(1'b0, 2'b00, 1'b1, "R7 sticky");
        do_reset();
        // R8: random legal traffic, rare illegal code
        for (int i = 0; i < 4000; i++) begin
            logic s, a;
            logic [1:0] k;
            s = ($urandom % 16) == 0;
            a = ($urandom % 4) != 0;
            k = 2'($urandom % 3);
            if (($urandom % 500) == 0) k = 2'b11;
            cyc(s, k, a, "R8 random");
            if (m_err && ($urandom % 8) == 0) do_reset();
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule